// File: doc/BRIEF.md
# T1 Receive Data-Link Bit Extractor

This block sits behind a T1 receive framer and pulls the data-link bits carried in the framing-bit position out of the received 1.544 MHz NRZ stream. An upstream synchronizer supplies a one-cycle frame marker, asserted in the same cycle as the framing bit. It also supplies the number of that frame within its multiframe. A mode input picks the framing format. That choice decides which frames carry a link bit: odd frames of the 24-frame extended superframe, even frames of the 12-frame superframe, or every fourth frame starting at frame 1 for the zero-byte time-slot-interchange format.

Each extracted bit is presented on `link_data` one clock before the next frame starts. A demand clock on `link_clk` goes with it, with one pulse per extracted bit. This gives a 4 kHz clock in the first two modes and 2 kHz in the third. A downstream serial receiver samples `link_data` on the rising edge of `link_clk`.

The receive stream is a plain serial flow with one bit every clock. There is no valid or ready on either side and no back-pressure: the line cannot be stalled, so the output must be taken as it comes.

Top module: `t1_rx_dlink`

## Requirements
- R1: While reset is asserted and afterwards until the first frame marker, `link_data` and `link_clk` are both 0.
- R2: With `mode` = 2'b00, a marker whose frame number is odd and in the range 1..24 captures `rx_data` of that cycle as the next link bit.
- R3: With `mode` = 2'b01, a marker whose frame number is even and in the range 2..12 captures the link bit; odd frames capture nothing.
- R4: With `mode` = 2'b10, only frame numbers 1, 5, 9, 13, 17 and 21 capture the link bit.
- R5: A frame is 193 clocks, with bit 0 being the marker cycle. A captured bit appears on `link_data` in the cycle of bit 192, one clock before the next marker, and `link_data` changes at no other time.
- R6: After a frame that captured a bit, `link_clk` is 1 from the next frame's bit 0 through its bit 191 and 0 in its bit 192. After a frame that captured nothing, `link_clk` stays 0 for the whole following frame.
- R7: With `mode` = 2'b11, no frame captures a bit: `link_data` holds and `link_clk` stays 0.
- R8: A marker that arrives before a frame's 193 bits are complete restarts the frame count. `link_clk` is dropped from the next cycle, and any bit captured by the cut-short frame is discarded.
- R9: Frame number 0, and any frame number above the multiframe length of the selected mode (24, or 12 with `mode` = 2'b01), captures nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered receive clock, one bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 1 | Received NRZ serial bit |
| frame_mark | input | 1 | High for the cycle carrying a framing bit |
| frame_num | input | 5 | Frame number within the multiframe, valid with `frame_mark` |
| mode | input | 2 | 00 extended superframe, 01 superframe, 10 zero-byte interchange, 11 off |
| link_data | output | 1 | Extracted link bit |
| link_clk | output | 1 | Demand clock for `link_data` |

## Verification
Full directed multiframes in each mode show that only the right frame numbers yield bits, and that neighbouring frames are skipped. Random framing bits and random payload tell a real capture of the framing position apart from a stale or wrong-position value. Out-of-range frame numbers, the off mode and truncated frames followed by an early marker are tried on their own. A random mix of modes and frame numbers, with the mode changing from frame to frame, then shows that the clock-pulse and data-update timing holds across any sequence of capturing and non-capturing frames.

// File: rtl/t1dl_pkg.sv
package t1dl_pkg;
  typedef enum logic [1:0] {
    DL_ESF = 2'b00,
    DL_D4  = 2'b01,
    DL_ZB  = 2'b10,
    DL_OFF = 2'b11
  } dl_mode_e;
endpackage

// File: rtl/t1dl_bitpos.sv
// Bit position within the current frame; 0 means no frame in progress.
module t1dl_bitpos #(
  parameter int FRAME_BITS = 193
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mark,
  output logic idle,
  output logic upd_tick,
  output logic end_tick
);
  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] PRE  = CW'(FRAME_BITS - 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (mark)           cnt <= CW'(1);
    else if (cnt == LAST)    cnt <= '0;
    else if (cnt != '0)      cnt <= cnt + 1'b1;
  end

  assign idle     = (cnt == '0);
  assign upd_tick = !mark && (cnt == PRE);
  assign end_tick = !mark && (cnt == LAST);

  // R8: any marker restarts counting at bit 1
  a_r8_mark_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    mark |=> (cnt == CW'(1)));
  // R5: the update slot is always followed by the last bit of the frame
  a_r5_update_then_last: assert property (@(posedge clk) disable iff (!rst_n)
    upd_tick |=> (cnt == LAST));
endmodule

// File: rtl/t1dl_frmsel.sv
// Decides whether the frame starting now carries a link bit.
module t1dl_frmsel
  import t1dl_pkg::*;
#(
  parameter int MF_FRAMES = 24,
  parameter int SF_FRAMES = 12,
  parameter int FW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mark,
  input  logic [FW-1:0] fnum,
  input  dl_mode_e      mode,
  output logic          take
);
  logic in_mf, in_sf;

  always_comb begin
    in_mf = (fnum != '0) && (32'(fnum) <= MF_FRAMES);
    in_sf = (fnum != '0) && (32'(fnum) <= SF_FRAMES);
    case (mode)
      DL_ESF:  take = mark && in_mf && fnum[0];
      DL_D4:   take = mark && in_sf && !fnum[0];
      DL_ZB:   take = mark && in_mf && (fnum[1:0] == 2'b01);
      default: take = 1'b0;
    endcase
  end

  a_r3_d4_even_only: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode == DL_D4) |-> !fnum[0]);
  a_r4_zb_every_fourth: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode == DL_ZB) |-> (fnum[1:0] == 2'b01));
  a_r7_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DL_OFF) |-> !take);
  a_r9_no_frame_zero: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (fnum != '0));
endmodule

// File: rtl/t1dl_linkout.sv
// Holds the captured bit, presents it on the update slot, drives the demand clock.
module t1dl_linkout (
  input  logic clk,
  input  logic rst_n,
  input  logic mark,
  input  logic idle,
  input  logic take,
  input  logic rx_data,
  input  logic upd_tick,
  input  logic end_tick,
  output logic link_data,
  output logic link_clk
);
  logic pend_d, pend_v, arm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_d    <= 1'b0;
      pend_v    <= 1'b0;
      arm       <= 1'b0;
      link_data <= 1'b0;
      link_clk  <= 1'b0;
    end else if (mark) begin
      pend_d <= rx_data;
      pend_v <= take;
      if (!idle) begin
        link_clk <= 1'b0;
        arm      <= 1'b0;
      end
    end else if (upd_tick) begin
      link_clk <= 1'b0;
      arm      <= pend_v;
      pend_v   <= 1'b0;
      if (pend_v) link_data <= pend_d;
    end else if (end_tick) begin
      link_clk <= arm;
    end
  end

  a_r5_data_moves_on_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(link_data) |-> $past(upd_tick));
  a_r6_clk_rises_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_clk) |-> $past(end_tick));
  a_r6_clk_low_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    upd_tick |=> !link_clk);
  a_r8_early_mark_drops_clk: assert property (@(posedge clk) disable iff (!rst_n)
    (mark && !idle) |=> !link_clk);
endmodule

// File: rtl/t1_rx_dlink.sv
module t1_rx_dlink
  import t1dl_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  parameter int MF_FRAMES  = 24,
  parameter int SF_FRAMES  = 12,
  parameter int FW         = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_data,
  input  logic          frame_mark,
  input  logic [FW-1:0] frame_num,
  input  logic [1:0]    mode,
  output logic          link_data,
  output logic          link_clk
);
  logic idle, upd_tick, end_tick, take;
  dl_mode_e mode_e;

  assign mode_e = dl_mode_e'(mode);

  t1dl_bitpos #(.FRAME_BITS(FRAME_BITS)) u_pos (
    .clk(clk), .rst_n(rst_n), .mark(frame_mark),
    .idle(idle), .upd_tick(upd_tick), .end_tick(end_tick)
  );

  t1dl_frmsel #(.MF_FRAMES(MF_FRAMES), .SF_FRAMES(SF_FRAMES), .FW(FW)) u_sel (
    .clk(clk), .rst_n(rst_n), .mark(frame_mark),
    .fnum(frame_num), .mode(mode_e), .take(take)
  );

  t1dl_linkout u_out (
    .clk(clk), .rst_n(rst_n), .mark(frame_mark), .idle(idle), .take(take),
    .rx_data(rx_data), .upd_tick(upd_tick), .end_tick(end_tick),
    .link_data(link_data), .link_clk(link_clk)
  );

  // R1: nothing is clocked out while no frame has started
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !frame_mark && !link_clk) |=> !link_clk);
endmodule

// File: tb/sim_t1_rx_dlink.sv
module sim_t1_rx_dlink;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_data = 1'b0;
  logic       frame_mark = 1'b0;
  logic [4:0] frame_num = '0;
  logic [1:0] mode = '0;
  logic       link_data, link_clk;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  bit  cur_data = 0;
  bit  prev_took = 0;
  bit  early = 0;

  always #5 clk = ~clk;

  t1_rx_dlink u0 (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .frame_mark(frame_mark),
    .frame_num(frame_num), .mode(mode), .link_data(link_data), .link_clk(link_clk)
  );

  function automatic bit ref_take(input logic [1:0] md, input int fn);
    case (md)
      2'b00:   return (fn >= 1 && fn <= 24 && (fn % 2) == 1);
      2'b01:   return (fn >= 2 && fn <= 12 && (fn % 2) == 0);
      2'b10:   return (fn >= 1 && fn <= 24 && (fn % 4) == 1);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string ref_tag(input logic [1:0] md, input int fn);
    if (md == 2'b11) return "R7";
    if (fn == 0 || fn > ((md == 2'b01) ? 12 : 24)) return "R9";
    case (md)
      2'b00:   return "R2";
      2'b01:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // One full 193-bit frame; outputs are checked at selected bit slots.
  task automatic do_frame(input logic [1:0] md, input int fn, input bit fb);
    bit tk = ref_take(md, fn);
    int rnd = 2 + int'($urandom % 188);
    for (int i = 0; i < 193; i++) begin
      @(negedge clk);
      if (i == 0 || i == 1 || i == 191 || i == 192 || i == rnd) begin
        if (i == 192) begin
          chk(link_clk, 1'b0, "R6", "clk low in last bit");
          chk(link_data, tk ? fb : cur_data, ref_tag(md, fn), "data in last bit");
        end else begin
          if (early && i != 0) chk(link_clk, 1'b0, "R8", "clk after early marker");
          else if (!early)     chk(link_clk, prev_took, "R6", "clk within frame");
          chk(link_data, cur_data, "R5", "data held mid-frame");
        end
      end
      frame_mark = (i == 0);
      frame_num  = 5'(fn);
      mode       = md;
      rx_data    = (i == 0) ? fb : 1'($urandom);
    end
    if (tk) cur_data = fb;
    prev_took = tk;
    early = 0;
  endtask

  // A frame cut short; the next marker arrives early.
  task automatic cut_frame(input logic [1:0] md, input int fn, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      frame_mark = (i == 0);
      frame_num  = 5'(fn);
      mode       = md;
      rx_data    = (i == 0) ? ~cur_data : 1'($urandom);
    end
    prev_took = 0;
    early = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    chk(link_data, 1'b0, "R1", "data in reset");
    chk(link_clk, 1'b0, "R1", "clk in reset");
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rx_data = 1'($urandom);
      chk(link_data, 1'b0, "R1", "data before first marker");
      chk(link_clk, 1'b0, "R1", "clk before first marker");
    end
    // directed multiframes
    for (int f = 1; f <= 24; f++) do_frame(2'b00, f, 1'($urandom));
    for (int f = 1; f <= 12; f++) do_frame(2'b01, f, 1'($urandom));
    for (int f = 1; f <= 12; f++) do_frame(2'b01, f, f[1]);
    for (int f = 1; f <= 24; f++) do_frame(2'b10, f, ~cur_data);
    for (int f = 1; f <= 6; f++)  do_frame(2'b11, f, ~cur_data);
    // range corners
    do_frame(2'b00, 1, 1'b1);
    do_frame(2'b01, 14, 1'b0);
    do_frame(2'b00, 0, 1'b0);
    do_frame(2'b00, 25, 1'b0);
    do_frame(2'b10, 3, 1'b0);
    do_frame(2'b10, 31, 1'b0);
    // truncated frames
    do_frame(2'b00, 3, 1'b0);
    cut_frame(2'b00, 5, 40);
    do_frame(2'b01, 3, 1'b1);
    do_frame(2'b00, 7, 1'b1);
    cut_frame(2'b00, 9, 150);
    do_frame(2'b00, 11, 1'b0);
    // random mix
    for (int k = 0; k < 80; k++) begin
      logic [1:0] md = 2'($urandom);
      int fn = ($urandom % 4 == 0) ? int'($urandom % 32) : 1 + int'($urandom % 24);
      if ($urandom % 10 == 0) cut_frame(md, fn, 5 + int'($urandom % 180));
      else do_frame(md, fn, 1'($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule